// File: doc/BRIEF.md
# Paged Memory Slot Selector

This block splits a 64 KB CPU memory space into four 16 KB pages. It routes each memory access to one of four slots by pulling one active-low select line low. Software writes a one-byte map register through a peripheral port. The register holds a 2-bit slot number for each page. During an access, the two most significant address bits pick the page. The slot number stored for that page is then decoded into the select line for that slot.

A write to the map is visible on readback at once. The copy that drives the selects only follows the written value at a clock edge where no memory request is active. A change to the map therefore never alters the select of an access that is already under way. Refresh cycles and idle bus cycles keep every select inactive.

Top module: `slot_selector`

## Requirements
- R1: After reset the map register reads 00h, and a non-refresh memory request anywhere in page 0 (addresses 0000h-3FFFh) drives sel_n to 1110b, which selects slot 0.
- R2: The page is taken from addr[15:14], with page p in 0..3. The slot number for page p is map bits [2p+1:2p]. Page 0 uses bits 1:0 and page 3 uses bits 7:6.
- R3: The select outputs are active low, and slot k corresponds to sel_n[k]. During a qualifying access only the bit of the chosen slot is 0.
- R4: While mreq_n is high, sel_n is 1111b.
- R5: While rfsh_n is low, sel_n is 1111b, even if mreq_n is low.
- R6: When map_wr is high at a rising clock edge, map_wr_data is stored. From the next cycle on, map_rd_data returns the last value stored.
- R7: A map write made while mreq_n is low leaves sel_n unchanged for the rest of that access. The new map steers the selects only after a rising clock edge at which mreq_n is high.
- R8: With the map set to ACh, page 0 selects slot 0, page 1 selects slot 3, and pages 2 and 3 select slot 2.
- R9: At no time is more than one bit of sel_n low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| map_wr | input | 1 | Write strobe for the map register |
| map_wr_data | input | 8 | Value to store in the map register |
| map_rd_data | output | 8 | Current contents of the map register |
| addr | input | 16 | CPU address bus |
| mreq_n | input | 1 | Active-low memory request |
| rfsh_n | input | 1 | Active-low refresh cycle indicator |
| sel_n | output | 4 | Active-low slot selects, where bit k selects slot k |

## Verification
The block keeps two pieces of state: the written map and the committed copy that drives decoding. An error in the written map appears on map_rd_data in the cycle after the write. An error in the committed copy is only visible on sel_n, and only once an access lands in the affected page. For that reason every random map value is probed with accesses to several pages. A commit that arrives too early shows up as sel_n changing in the middle of an access. A commit that never arrives shows up as a stale select on the first access after an idle edge.

// File: rtl/slot_selector_pkg.sv
package slot_selector_pkg;
  localparam int unsigned DEF_PAGES     = 4;
  localparam int unsigned DEF_SLOT_BITS = 2;
  localparam int unsigned DEF_ADDR_W    = 16;
endpackage

// File: rtl/slot_map_store.sv
module slot_map_store #(
  parameter int unsigned MAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [MAP_W-1:0] wr_data,
  input  logic             bus_idle,
  output logic [MAP_W-1:0] written_q,
  output logic [MAP_W-1:0] active_q
);
  logic [MAP_W-1:0] written_d;
  logic [MAP_W-1:0] active_d;

  always_comb begin
    written_d = written_q;
    if (wr_en) written_d = wr_data;
  end

  // commit only between accesses
  always_comb begin
    active_d = active_q;
    if (bus_idle) active_d = written_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      written_q <= '0;
      active_q  <= '0;
    end else begin
      written_q <= written_d;
      active_q  <= active_d;
    end
  end
endmodule

// File: rtl/page_field_mux.sv
module page_field_mux #(
  parameter int unsigned PAGES     = 4,
  parameter int unsigned SLOT_BITS = 2,
  localparam int unsigned PAGE_BITS = $clog2(PAGES),
  localparam int unsigned MAP_W     = PAGES * SLOT_BITS
) (
  input  logic [MAP_W-1:0]     map,
  input  logic [PAGE_BITS-1:0] page,
  output logic [SLOT_BITS-1:0] slot
);
  logic [SLOT_BITS-1:0] fields [PAGES];

  for (genvar p = 0; p < PAGES; p++) begin : g_field
    assign fields[p] = map[p*SLOT_BITS +: SLOT_BITS];
  end

  always_comb begin
    slot = fields[page];
  end
endmodule

// File: rtl/slot_decoder.sv
module slot_decoder #(
  parameter int unsigned SLOT_BITS = 2,
  localparam int unsigned SLOTS = 1 << SLOT_BITS
) (
  input  logic                 enable,
  input  logic [SLOT_BITS-1:0] slot,
  output logic [SLOTS-1:0]     sel_n
);
  for (genvar k = 0; k < SLOTS; k++) begin : g_line
    assign sel_n[k] = !(enable && (slot == SLOT_BITS'(k)));
  end
endmodule

// File: rtl/slot_selector.sv
module slot_selector
  import slot_selector_pkg::*;
#(
  parameter int unsigned PAGES     = DEF_PAGES,
  parameter int unsigned SLOT_BITS = DEF_SLOT_BITS,
  parameter int unsigned ADDR_W    = DEF_ADDR_W,
  localparam int unsigned PAGE_BITS = $clog2(PAGES),
  localparam int unsigned MAP_W     = PAGES * SLOT_BITS,
  localparam int unsigned SLOTS     = 1 << SLOT_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              map_wr,
  input  logic [MAP_W-1:0]  map_wr_data,
  output logic [MAP_W-1:0]  map_rd_data,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mreq_n,
  input  logic              rfsh_n,
  output logic [SLOTS-1:0]  sel_n
);
  logic [1:0]           rst_sync_q;
  logic                 rst_int_n;
  logic [MAP_W-1:0]     active_map;
  logic [SLOT_BITS-1:0] slot_num;
  logic [PAGE_BITS-1:0] page;
  logic                 access_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign page      = addr[ADDR_W-1 -: PAGE_BITS];
  assign access_en = !mreq_n && rfsh_n;

  slot_map_store #(.MAP_W(MAP_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (map_wr),
    .wr_data   (map_wr_data),
    .bus_idle  (mreq_n),
    .written_q (map_rd_data),
    .active_q  (active_map)
  );

  page_field_mux #(.PAGES(PAGES), .SLOT_BITS(SLOT_BITS)) u_mux (
    .map  (active_map),
    .page (page),
    .slot (slot_num)
  );

  slot_decoder #(.SLOT_BITS(SLOT_BITS)) u_dec (
    .enable (access_en),
    .slot   (slot_num),
    .sel_n  (sel_n)
  );
endmodule

// File: rtl/slot_selector_checker.sv
module slot_selector_checker #(
  parameter int unsigned MAP_W  = 8,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned SLOTS  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              map_wr,
  input logic [MAP_W-1:0]  map_wr_data,
  input logic [MAP_W-1:0]  map_rd_data,
  input logic [ADDR_W-1:0] addr,
  input logic              mreq_n,
  input logic              rfsh_n,
  input logic [SLOTS-1:0]  sel_n
);
  AST_IDLE_ALL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_n |-> (sel_n == '1)); // R4
  AST_REFRESH_ALL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !rfsh_n |-> (sel_n == '1)); // R5
  AST_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~sel_n)); // R9
  AST_EXACTLY_ONE_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mreq_n && rfsh_n) |-> ($countones(~sel_n) == 1)); // R3
  AST_READBACK_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    map_wr |=> (map_rd_data == $past(map_wr_data))); // R6
  AST_SELECT_HELD_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mreq_n && rfsh_n) |=> ((!mreq_n && rfsh_n && $stable(addr[ADDR_W-1 -: 2]))
                             -> $stable(sel_n))); // R7
endmodule

bind slot_selector slot_selector_checker #(
  .MAP_W(MAP_W), .ADDR_W(ADDR_W), .SLOTS(SLOTS)
) u_checker (
  .clk(clk), .rst_n(rst_n), .map_wr(map_wr), .map_wr_data(map_wr_data),
  .map_rd_data(map_rd_data), .addr(addr), .mreq_n(mreq_n), .rfsh_n(rfsh_n),
  .sel_n(sel_n)
);

// File: tb/slot_selector_test.sv
`timescale 1ns/1ps
module slot_selector_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        map_wr;
  logic [7:0]  map_wr_data;
  logic [7:0]  map_rd_data;
  logic [15:0] addr;
  logic        mreq_n;
  logic        rfsh_n;
  logic [3:0]  sel_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [7:0] model_map;

  always #5 clk = ~clk;

  slot_selector uut (
    .clk(clk), .rst_n(rst_n), .map_wr(map_wr), .map_wr_data(map_wr_data),
    .map_rd_data(map_rd_data), .addr(addr), .mreq_n(mreq_n), .rfsh_n(rfsh_n),
    .sel_n(sel_n)
  );

  function automatic logic [3:0] exp_sel(input logic [7:0] m, input logic [15:0] a,
                                         input logic mq_n, input logic rf_n);
    logic [1:0] s;
    if (mq_n || !rf_n) return 4'b1111;
    s = m[2*a[15:14] +: 2];
    return ~(4'b0001 << s);
  endfunction

  task automatic check4(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // write with bus idle, then one idle edge to commit
  task automatic write_map(input logic [7:0] v);
    @(negedge clk);
    map_wr = 1'b1; map_wr_data = v; mreq_n = 1'b1; rfsh_n = 1'b1;
    @(negedge clk);
    map_wr = 1'b0;
    @(negedge clk);
    model_map = v;
  endtask

  task automatic access(input string req, input logic [15:0] a, input logic rf_n);
    @(negedge clk);
    addr = a; mreq_n = 1'b0; rfsh_n = rf_n;
    #1 check4(req, sel_n, exp_sel(model_map, a, 1'b0, rf_n));
    @(negedge clk);
    mreq_n = 1'b1; rfsh_n = 1'b1;
    #1 check4("R4", sel_n, 4'b1111);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; map_wr = 1'b0; map_wr_data = '0; addr = '0;
    mreq_n = 1'b1; rfsh_n = 1'b1; model_map = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check8("R1", map_rd_data, 8'h00);
    check4("R4", sel_n, 4'b1111);
    access("R1", 16'h0000, 1'b1);
    access("R1", 16'h3FFF, 1'b1);

    // R8 ACh example, each page
    write_map(8'hAC);
    check8("R6", map_rd_data, 8'hAC);
    access("R8", 16'h0123, 1'b1);
    check4("R8", exp_sel(8'hAC, 16'h0123, 0, 1), 4'b1110);
    access("R8", 16'h4000, 1'b1);
    check4("R8", exp_sel(8'hAC, 16'h4000, 0, 1), 4'b0111);
    access("R8", 16'hBFFF, 1'b1);
    access("R8", 16'hC000, 1'b1);
    access("R8", 16'hFFFF, 1'b1);

    // R2 / R3 page boundaries, one slot per page
    write_map(8'b00_01_10_11);
    access("R2", 16'h3FFF, 1'b1);
    access("R2", 16'h4000, 1'b1);
    access("R3", 16'h7FFF, 1'b1);
    access("R3", 16'h8000, 1'b1);
    access("R2", 16'hC000, 1'b1);

    // R5 refresh keeps selects high
    access("R5", 16'h0000, 1'b0);
    access("R5", 16'hC123, 1'b0);

    // R7 write during an access
    write_map(8'h00);
    @(negedge clk);
    addr = 16'h4321; mreq_n = 1'b0; rfsh_n = 1'b1;
    map_wr = 1'b1; map_wr_data = 8'hFF;
    #1 check4("R7", sel_n, 4'b1110);
    @(negedge clk);
    map_wr = 1'b0;
    #1 check4("R7", sel_n, 4'b1110);
    check8("R6", map_rd_data, 8'hFF);
    @(negedge clk);
    #1 check4("R7", sel_n, 4'b1110);
    mreq_n = 1'b1;
    @(negedge clk);
    model_map = 8'hFF;
    access("R7", 16'h4321, 1'b1);
    check4("R7", exp_sel(8'hFF, 16'h4321, 0, 1), 4'b0111);

    // random maps with several accesses each
    for (int i = 0; i < 300; i++) begin
      logic [7:0] v;
      v = 8'($urandom);
      write_map(v);
      check8("R6", map_rd_data, v);
      for (int j = 0; j < 4; j++) begin
        logic [15:0] a;
        a = 16'($urandom);
        access(($urandom % 8 == 0) ? "R5" : "R2", a, ($urandom % 8) != 0);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule